// File: doc/BRIEF.md
# Parallel Port Reverse-Channel Byte Receiver

This block is the host end of the reverse direction of an enhanced parallel port link. When the local logic asks for reverse traffic, the block requests the channel from the peripheral. After the peripheral grants the channel, the block runs the per-byte handshake: the peripheral presents a byte and strobes its clock line, and the host answers on its acknowledge line.

Every byte received is delivered on a valid/ready output, together with a flag that marks it as a command byte or a data byte. All peripheral-side lines are asynchronous to the local clock, so they pass through a multi-stage synchronizer first. Edge detection is done on the synchronized strobe.

Back-pressure from the sink reaches the cable. While the single output slot is occupied, the host acknowledge stays high, which stops the peripheral from starting another byte. Dropping the enable input releases the channel, but only once any byte already in progress has completed.

Top module: `prt_rev_rx`

## Requirements
- R1: While reset is asserted and after it is released, `rev_req_no` is 1, `host_ack_o` is 0 and `valid_o` is 0.
- R2: When `rev_en_i` is 1 and no byte is in progress, `rev_req_no` is driven low. When `rev_en_i` is 0 and no byte is in progress, `rev_req_no` returns high.
- R3: No byte is acknowledged or delivered before the synchronized `ack_rev_ni` has been seen low while the channel is requested. Strobe activity before the grant leaves `host_ack_o` at 0 and `valid_o` at 0.
- R4: Once the channel is granted, a falling edge on the synchronized `pclk_i` drives `host_ack_o` to 1.
- R5: The level of `pack_i` at the strobe's falling edge sets the byte type. A level of 1 gives `is_cmd_o`=0 (data byte). A level of 0 gives `is_cmd_o`=1 (command byte).
- R6: The value on `pdata_i` at the rising edge of the synchronized `pclk_i` is the value delivered on `byte_o`. Bytes are delivered in the order they were received.
- R7: After the rising edge, and once the output slot is empty, the byte is placed in the slot (`valid_o` goes to 1) in the same cycle that `host_ack_o` returns to 0.
- R8: While the output slot is occupied and not being read, a received byte waits, and `host_ack_o` stays at 1.
- R9: A release (`rev_en_i` going to 0) during a byte does not raise `rev_req_no` until that byte has been completed and `host_ack_o` has returned to 0.
- R10: While `valid_o` is 1 and `ready_i` is 0, `valid_o`, `byte_o` and `is_cmd_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rev_en_i | input | 1 | Level request to hold the reverse channel open |
| ack_rev_ni | input | 1 | Peripheral grant of the reverse channel, active low |
| pclk_i | input | 1 | Peripheral byte strobe (falling edge means valid, rising edge means capture) |
| pack_i | input | 1 | Peripheral byte-type line (1 means data, 0 means command) |
| pdata_i | input | DATA_W | Cable data lines |
| ready_i | input | 1 | Sink accepts the output byte |
| rev_req_no | output | 1 | Reverse channel request to the peripheral, active low |
| host_ack_o | output | 1 | Host acknowledge to the peripheral |
| valid_o | output | 1 | Output byte is valid |
| byte_o | output | DATA_W | Received byte |
| is_cmd_o | output | 1 | 1 when the output byte is a command byte |

## Verification
The bench builds the receiver with DATA_W=8 and SYNC_STAGES=3. It uses one synchronizer stage more than the default, so that every check waits on handshake levels and never counts latency cycles. The deeper pipeline widens the window in which a stale strobe level could leak through. That brings within reach the pre-grant strobe, a release issued while acknowledge is high, and a second byte that waits behind an unread first byte. Both byte types are sent, with data patterns that have alternating bits and with all bits set or all bits clear.

// File: rtl/prt_rev_rx_pkg.sv
package prt_rev_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_OPEN,
    ST_STROBED,
    ST_HOLD
  } rx_state_e;
endpackage

// File: rtl/prt_rev_rx_sync.sv
module prt_rev_rx_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= RST_VAL;
        else         pipe_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= RST_VAL;
        else         pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/prt_rev_rx_fsm.sv
module prt_rev_rx_fsm
  import prt_rev_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic grant_n_i,   // synchronized
  input  logic strobe_i,    // synchronized
  input  logic slot_full_i,
  output logic req_no,
  output logic ack_o,
  output logic type_we_o,
  output logic data_we_o,
  output logic push_o
);
  rx_state_e state_q, state_d;
  logic      strobe_d;
  logic      fall, rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      strobe_d <= 1'b1;
    end else begin
      state_q  <= state_d;
      strobe_d <= strobe_i;
    end
  end

  assign fall = strobe_d & ~strobe_i;
  assign rise = ~strobe_d & strobe_i;

  always_comb begin
    state_d   = state_q;
    type_we_o = 1'b0;
    data_we_o = 1'b0;
    push_o    = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (en_i) state_d = ST_REQ;
      ST_REQ: begin
        if (!en_i)          state_d = ST_IDLE;
        else if (!grant_n_i) state_d = ST_OPEN;
      end
      ST_OPEN: begin
        // a started byte wins over a release
        if (fall) begin
          type_we_o = 1'b1;
          state_d   = ST_STROBED;
        end else if (!en_i) begin
          state_d = ST_IDLE;
        end
      end
      ST_STROBED: if (rise) begin
        data_we_o = 1'b1;
        state_d   = ST_HOLD;
      end
      ST_HOLD: if (!slot_full_i) begin
        push_o  = 1'b1;
        state_d = en_i ? ST_OPEN : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign req_no = (state_q == ST_IDLE);
  assign ack_o  = (state_q == ST_STROBED) || (state_q == ST_HOLD);
endmodule

// File: rtl/prt_rev_rx_slot.sv
module prt_rev_rx_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              type_we_i,
  input  logic              cmd_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              push_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              is_cmd_o
);
  logic              cap_cmd_q;
  logic [DATA_W-1:0] cap_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_cmd_q  <= 1'b0;
      cap_data_q <= '0;
      valid_o    <= 1'b0;
      byte_o     <= '0;
      is_cmd_o   <= 1'b0;
    end else begin
      if (type_we_i) cap_cmd_q  <= cmd_i;
      if (data_we_i) cap_data_q <= data_i;
      if (push_i) begin
        valid_o  <= 1'b1;
        byte_o   <= cap_data_q;
        is_cmd_o <= cap_cmd_q;
      end else if (valid_o && ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prt_rev_rx.sv
module prt_rev_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rev_en_i,
  input  logic              ack_rev_ni,
  input  logic              pclk_i,
  input  logic              pack_i,
  input  logic [DATA_W-1:0] pdata_i,
  input  logic              ready_i,
  output logic              rev_req_no,
  output logic              host_ack_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              is_cmd_o
);
  localparam int SW = DATA_W + 3;

  logic [SW-1:0]     raw, synced;
  logic              grant_n_s, strobe_s, pack_s;
  logic [DATA_W-1:0] data_s;
  logic              type_we, data_we, push;

  assign raw = {ack_rev_ni, pclk_i, pack_i, pdata_i};

  prt_rev_rx_sync #(
    .W(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(synced)
  );

  assign {grant_n_s, strobe_s, pack_s, data_s} = synced;

  prt_rev_rx_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (rev_en_i),
    .grant_n_i  (grant_n_s),
    .strobe_i   (strobe_s),
    .slot_full_i(valid_o),
    .req_no     (rev_req_no),
    .ack_o      (host_ack_o),
    .type_we_o  (type_we),
    .data_we_o  (data_we),
    .push_o     (push)
  );

  prt_rev_rx_slot #(.DATA_W(DATA_W)) u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .type_we_i(type_we),
    .cmd_i    (~pack_s),
    .data_we_i(data_we),
    .data_i   (data_s),
    .push_i   (push),
    .ready_i  (ready_i),
    .valid_o  (valid_o),
    .byte_o   (byte_o),
    .is_cmd_o (is_cmd_o)
  );
endmodule

// File: rtl/prt_rev_rx_chk.sv
module prt_rev_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_i,
  input logic              rev_req_no,
  input logic              host_ack_o,
  input logic              valid_o,
  input logic [DATA_W-1:0] byte_o,
  input logic              is_cmd_o
);
  p_ack_only_requested_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ack_o |-> !rev_req_no);

  p_ack_drop_loads_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_ack_o) |-> valid_o);

  p_throttle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && host_ack_o) |=> host_ack_o);

  p_release_after_byte_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rev_req_no) |-> !host_ack_o);

  p_slot_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(byte_o) && $stable(is_cmd_o)));

  always_comb begin
    if (!rst_ni) begin
      a_reset_idle_r1: assert (rev_req_no && !host_ack_o && !valid_o);
    end
  end
endmodule

bind prt_rev_rx prt_rev_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_i   (ready_i),
  .rev_req_no(rev_req_no),
  .host_ack_o(host_ack_o),
  .valid_o   (valid_o),
  .byte_o    (byte_o),
  .is_cmd_o  (is_cmd_o)
);

// File: tb/prt_rev_rx_tb_top.sv
module prt_rev_rx_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0, ack_rev_n = 1'b1, pclk = 1'b1, pack = 1'b1, ready = 1'b1;
  logic [DW-1:0] pdata = '0;
  logic          req_n, hack, valid, is_cmd;
  logic [DW-1:0] byte_out;

  int n_cmp = 0, n_bad = 0;
  logic [DW:0] exp_q[$];

  always #5 clk = ~clk;

  prt_rev_rx #(.DATA_W(DW), .SYNC_STAGES(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rev_en_i(en), .ack_rev_ni(ack_rev_n),
    .pclk_i(pclk), .pack_i(pack), .pdata_i(pdata), .ready_i(ready),
    .rev_req_no(req_n), .host_ack_o(hack), .valid_o(valid),
    .byte_o(byte_out), .is_cmd_o(is_cmd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ack(input logic lvl, input string req);
    int t = 0;
    while (hack !== lvl && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(req, hack, lvl);
  endtask

  // scoreboard monitor (R5, R6 ordering)
  always @(negedge clk) begin
    if (rst_n && valid && ready) begin
      if (exp_q.size() == 0) begin
        chk("R6 unexpected byte", {is_cmd, byte_out}, 32'hFFFF);
      end else begin
        logic [DW:0] e;
        e = exp_q.pop_front();
        chk("R5/R6 byte and type", {is_cmd, byte_out}, e);
      end
    end
  end

  task automatic start_byte(input logic cmd, input logic [DW-1:0] d);
    exp_q.push_back({cmd, d});
    pdata = d;
    pack  = ~cmd;
    cyc(2);
    pclk = 1'b0;
    wait_ack(1'b1, "R4 ack on strobe fall");
    // change type line after the fall; must not affect the byte
    pack = cmd;
  endtask

  task automatic send(input logic cmd, input logic [DW-1:0] d);
    start_byte(cmd, d);
    pclk = 1'b1;
    wait_ack(1'b0, "R7 ack release after capture");
    pdata = ~d;
    cyc(2);
  endtask

  initial begin
    cyc(3);
    chk("R1 reset req_n", req_n, 1);
    chk("R1 reset ack", hack, 0);
    chk("R1 reset valid", valid, 0);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 post-reset req_n", req_n, 1);

    en = 1'b1;
    cyc(2);
    chk("R2 request driven low", req_n, 0);

    // R3: strobe before grant
    pdata = 8'h3C;
    pclk  = 1'b0;
    cyc(12);
    chk("R3 no ack before grant", hack, 0);
    chk("R3 no byte before grant", valid, 0);
    pclk = 1'b1;
    cyc(8);
    chk("R3 still nothing delivered", valid, 0);

    ack_rev_n = 1'b0;
    cyc(8);

    send(1'b0, 8'hA5);
    send(1'b1, 8'h5A);
    send(1'b0, 8'hFF);
    send(1'b1, 8'h00);

    // R8 / R10: throttling
    ready = 1'b0;
    send(1'b0, 8'h11);
    cyc(2);
    chk("R7 slot filled", valid, 1);
    start_byte(1'b1, 8'h22);
    pclk = 1'b1;
    cyc(20);
    chk("R8 ack held while slot full", hack, 1);
    chk("R10 valid held", valid, 1);
    chk("R10 byte held", {is_cmd, byte_out}, {1'b0, 8'h11});
    ready = 1'b1;
    wait_ack(1'b0, "R8 ack drops after drain");
    cyc(4);

    // R9: release during a byte
    start_byte(1'b0, 8'hC3);
    en = 1'b0;
    cyc(10);
    chk("R9 request held mid-byte", req_n, 0);
    pclk = 1'b1;
    wait_ack(1'b0, "R9 byte completes");
    cyc(2);
    chk("R2 request released after byte", req_n, 1);
    ack_rev_n = 1'b1;
    cyc(6);
    chk("R6 all bytes delivered", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule